// File: doc/BRIEF.md
# SATA Port Control and Interrupt Register Block

This block is the software-visible control and interrupt register file for one SATA host port. A 32-bit register port gives access to a bank of port control bits and an interrupt enable bank. Neither is written with a plain store. One address sets the bits that are 1 in the written word, and another address clears them. The same register bank is read back as a status word that also reports whether the port is ready to accept commands.

A port engine reports events as single-cycle pulses. The block latches each pulse as a pending cause. The interrupt status word shows the raw cause in its upper half and the cause gated by its enable in its lower half. A control bit selects how pending causes are removed: by a read of the status word (the default) or by writing ones to it. The block drives one interrupt line and a two-bit steering code that a neighbouring interrupt router decodes.

A device reset, started from the control bank, runs for a fixed number of cycles and then clears itself. At the end of the reset the port becomes ready and every pending cause is flushed.

Top module: `sata_port_csr`

## Requirements
- R1: After reset, the status word at 0x000 reads 0x00000001 (port reset set, all other control bits 0, ready 0). The enable word at 0x010 reads 0 and the interrupt status word at 0x008 reads 0. `irq_o` is 0.
- R2: A write to 0x000 sets, and a write to 0x004 clears, the control bits that are 1 in the data. Only these bits exist: 0 port reset, 1 device reset, 2 port initialize, 3 write-one-to-clear mode, 6 resume, 10 32-bit activation, 13 port multiplier enable. Other data bits have no effect and read back as 0. Control bits [13:0] read back in status bits [13:0].
- R3: Status bit 31 (ready) reads 1 only while both port reset and device reset are 0.
- R4: Setting device reset holds the bit at 1 for DEVRST_CYC cycles (16 by default). It then returns to 0 on its own, ready rises if port reset is 0, and all pending causes clear.
- R5: A write to 0x010 sets, and a write to 0x014 clears, the enable bits that are 1 in data bits [11:0]. Only cause positions 0–6 and 11 exist. Data bits [31:30] set or clear the steering code in the same way. The enable word reads back as {steering, 18'b0, enables}, and the steering code drives `irq_steer_o`.
- R6: A pulse on `evt_i[k]` latches cause k whatever its enable. Cause positions are: 0 command complete, 1 command error, 2 port-ready change, 3 power change, 4 PHY-ready change, 5 wake signal received, 6 unknown frame, 11 set-device-bits frame. Pulses on bits 7–10 are ignored. Reading 0x008 gives the raw causes in bits [27:16] and the enabled causes in bits [11:0].
- R7: `irq_o` is the OR of the enabled causes. It changes in the cycle after the event pulse or the register write that changed them.
- R8: With write-one-to-clear mode off, a read of 0x008 clears the enabled causes that it returned. Causes that are not enabled stay pending, and writes to 0x008 have no effect.
- R9: With write-one-to-clear mode on, reads of 0x008 do not clear anything. A write to 0x008 clears cause k if data bit k or data bit k+16 is 1, so writing 0x0FFF0FFF clears every cause.
- R10: If an event pulse and a clear of the same cause happen in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clear-on-read takes effect at the edge) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| evt_i | input | 12 | Event pulses from the port engine, one per cause position |
| ctrl_o | output | 14 | Current control bits |
| port_ready_o | output | 1 | Port ready to accept commands |
| irq_o | output | 1 | Interrupt request |
| irq_steer_o | output | 2 | Interrupt steering code |

## Verification
A wrong cause or enable bit shows on `irq_o` one cycle after the pulse or write that set it. It also shows in both halves of the very next read of the status word. A wrong clear mode shows at once: a second read returns the same value when it should return nothing, or a write-one-to-clear leaves bits set. A wrong device reset counter is visible only at its end. The reset bit drops early or late, and the ready flag and the flush of causes move with it. The bench therefore checks the cycle just before and the cycle just after the expected end.

// File: rtl/sata_port_csr_pkg.sv
package sata_port_csr_pkg;

   localparam int CSR_DW   = 32;
   localparam int CTRL_W   = 14;
   localparam int NCAUSE   = 12;
   localparam int STEER_W  = 2;
   localparam int RAW_SHIFT = 16;

   // register byte offsets
   localparam int unsigned OFF_CTRL_SET = 32'h000;
   localparam int unsigned OFF_CTRL_CLR = 32'h004;
   localparam int unsigned OFF_IRQ_STAT = 32'h008;
   localparam int unsigned OFF_EN_SET   = 32'h010;
   localparam int unsigned OFF_EN_CLR   = 32'h014;

   // control bit positions
   localparam int CB_PORT_RST = 0;
   localparam int CB_DEV_RST  = 1;
   localparam int CB_INIT     = 2;
   localparam int CB_WOC      = 3;
   localparam int CB_RESUME   = 6;
   localparam int CB_ACT32    = 10;
   localparam int CB_PMUL     = 13;

   localparam logic [CTRL_W-1:0] CTRL_IMPL =
      CTRL_W'((1 << CB_PORT_RST) | (1 << CB_DEV_RST) | (1 << CB_INIT) |
              (1 << CB_WOC) | (1 << CB_RESUME) | (1 << CB_ACT32) | (1 << CB_PMUL));
   localparam logic [CTRL_W-1:0] CTRL_RST_VAL = CTRL_W'(1 << CB_PORT_RST);

   // implemented cause positions: 0..6 and 11
   localparam logic [NCAUSE-1:0] CAUSE_IMPL = 12'h87F;

   typedef struct packed {
      logic ctrl_set;
      logic ctrl_clr;
      logic irq_wr;
      logic irq_rd;
      logic en_set;
      logic en_clr;
   } csr_hit_t;

endpackage

// File: rtl/spc_ctrl_reg.sv
module spc_ctrl_reg
   import sata_port_csr_pkg::*;
#(
   parameter int DEVRST_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [CTRL_W-1:0] wbits,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              ready,
   output logic              devrst_done
);
   localparam int CW = (DEVRST_CYC < 2) ? 1 : $clog2(DEVRST_CYC);
   localparam logic [CW-1:0] LOAD_VAL = CW'(DEVRST_CYC - 1);

   logic [CTRL_W-1:0] live_bits;
   logic [CTRL_W-1:0] ctrl_n;
   logic [CW-1:0]     cnt_q;
   logic              start;

   assign live_bits   = wbits & CTRL_IMPL;
   assign start       = set_we && wbits[CB_DEV_RST] && !ctrl_q[CB_DEV_RST];
   assign devrst_done = ctrl_q[CB_DEV_RST] && (cnt_q == '0);

   always_comb begin
      ctrl_n = ctrl_q;
      if (set_we) ctrl_n = ctrl_n | live_bits;
      if (clr_we) ctrl_n = ctrl_n & ~live_bits;
      if (devrst_done) ctrl_n[CB_DEV_RST] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST_VAL;
         cnt_q  <= '0;
      end else begin
         ctrl_q <= ctrl_n;
         if (start)
            cnt_q <= LOAD_VAL;
         else if (ctrl_q[CB_DEV_RST] && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = !ctrl_q[CB_PORT_RST] && !ctrl_q[CB_DEV_RST];

endmodule

// File: rtl/spc_irq_enable.sv
module spc_irq_enable
   import sata_port_csr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NCAUSE-1:0]  wen,
   input  logic [STEER_W-1:0] wsteer,
   output logic [NCAUSE-1:0]  en_q,
   output logic [STEER_W-1:0] steer_q
);
   logic [NCAUSE-1:0] en_bits;
   assign en_bits = wen & CAUSE_IMPL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         steer_q <= '0;
      end else begin
         if (set_we) begin
            en_q    <= en_q | en_bits;
            steer_q <= steer_q | wsteer;
         end else if (clr_we) begin
            en_q    <= en_q & ~en_bits;
            steer_q <= steer_q & ~wsteer;
         end
      end
   end

endmodule

// File: rtl/spc_irq_cause.sv
module spc_irq_cause
   import sata_port_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAUSE-1:0] evt,
   input  logic [NCAUSE-1:0] clr,
   input  logic              flush,
   output logic [NCAUSE-1:0] cause_q
);
   for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
      if (CAUSE_IMPL[i]) begin : g_live
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b0;
            else if (flush)  q <= 1'b0;
            else if (evt[i]) q <= 1'b1;
            else if (clr[i]) q <= 1'b0;
         end
         assign cause_q[i] = q;
      end else begin : g_tie
         logic unused_in;
         assign unused_in  = evt[i] ^ clr[i];
         assign cause_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/sata_port_csr.sv
module sata_port_csr
   import sata_port_csr_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DEVRST_CYC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NCAUSE-1:0]  evt_i,
   output logic [CTRL_W-1:0]  ctrl_o,
   output logic               port_ready_o,
   output logic               irq_o,
   output logic [STEER_W-1:0] irq_steer_o
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("sata_port_csr: ADDR_W must reach offset 0x014");
   end
   if (DEVRST_CYC < 1) begin : g_bad_cyc
      $error("sata_port_csr: DEVRST_CYC must be at least 1");
   end

   csr_hit_t          hit;
   logic [NCAUSE-1:0] en_q;
   logic [NCAUSE-1:0] cause_q;
   logic [NCAUSE-1:0] masked;
   logic [NCAUSE-1:0] clr_bits;
   logic              devrst_done;
   logic              woc;
   logic              unused_wd;

   assign unused_wd = ^bus_wdata[29:28];

   // address decode
   always_comb begin
      hit.ctrl_set = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL_SET));
      hit.ctrl_clr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL_CLR));
      hit.irq_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ_STAT));
      hit.irq_rd   = bus_rd && (bus_addr == ADDR_W'(OFF_IRQ_STAT));
      hit.en_set   = bus_wr && (bus_addr == ADDR_W'(OFF_EN_SET));
      hit.en_clr   = bus_wr && (bus_addr == ADDR_W'(OFF_EN_CLR));
   end

   spc_ctrl_reg #(.DEVRST_CYC(DEVRST_CYC)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_we      (hit.ctrl_set),
      .clr_we      (hit.ctrl_clr),
      .wbits       (bus_wdata[CTRL_W-1:0]),
      .ctrl_q      (ctrl_o),
      .ready       (port_ready_o),
      .devrst_done (devrst_done)
   );

   spc_irq_enable u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (hit.en_set),
      .clr_we  (hit.en_clr),
      .wen     (bus_wdata[NCAUSE-1:0]),
      .wsteer  (bus_wdata[31:32-STEER_W]),
      .en_q    (en_q),
      .steer_q (irq_steer_o)
   );

   assign woc    = ctrl_o[CB_WOC];
   assign masked = cause_q & en_q;

   // clear source: returned masked causes on read, or written ones in either half
   always_comb begin
      clr_bits = '0;
      if (woc && hit.irq_wr)
         clr_bits = bus_wdata[NCAUSE-1:0] | bus_wdata[RAW_SHIFT+NCAUSE-1:RAW_SHIFT];
      else if (!woc && hit.irq_rd)
         clr_bits = masked;
   end

   spc_irq_cause u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_i),
      .clr     (clr_bits),
      .flush   (devrst_done),
      .cause_q (cause_q)
   );

   assign irq_o = |masked;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_W'(OFF_CTRL_SET))
            bus_rdata = {port_ready_o, {(CSR_DW-1-CTRL_W){1'b0}}, ctrl_o};
         else if (bus_addr == ADDR_W'(OFF_IRQ_STAT))
            bus_rdata = (CSR_DW'(cause_q) << RAW_SHIFT) | CSR_DW'(masked);
         else if (bus_addr == ADDR_W'(OFF_EN_SET))
            bus_rdata = {irq_steer_o, {(CSR_DW-STEER_W-NCAUSE){1'b0}}, en_q};
      end
   end

endmodule

// File: rtl/spc_csr_chk.sv
module spc_csr_chk
   import sata_port_csr_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DEVRST_CYC = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NCAUSE-1:0] evt_i,
   input logic [CTRL_W-1:0] ctrl_o,
   input logic              port_ready_o,
   input logic              irq_o,
   input logic [NCAUSE-1:0] en_q,
   input logic [NCAUSE-1:0] cause_q
);
   int hi_cnt;
   logic stat_rd;
   logic quiet;

   assign stat_rd = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFF_IRQ_STAT));
   assign quiet   = (evt_i == '0) && !ctrl_o[CB_DEV_RST];

   always_ff @(posedge clk) begin
      if (!rst_n)                 hi_cnt <= 0;
      else if (ctrl_o[CB_DEV_RST]) hi_cnt <= hi_cnt + 1;
      else                        hi_cnt <= 0;
   end

   // R3
   p_rst_blocks_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[CB_PORT_RST] || ctrl_o[CB_DEV_RST]) |-> !port_ready_o);

   // R4
   p_devrst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cnt <= DEVRST_CYC);

   // R4
   p_devrst_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_o[CB_DEV_RST]) |-> (cause_q == '0));

   // R6
   p_evt_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & CAUSE_IMPL) != '0 && !ctrl_o[CB_DEV_RST]) |=>
      ((cause_q & $past(evt_i & CAUSE_IMPL)) == $past(evt_i & CAUSE_IMPL)));

   // R7
   p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & en_q) != '0 && !ctrl_o[CB_DEV_RST] && !bus_wr) |=> irq_o);

   // R8
   p_rc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_o[CB_WOC] && stat_rd && quiet) |=>
      ((cause_q & $past(cause_q & en_q)) == '0));

   // R9
   p_woc_read_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[CB_WOC] && stat_rd && quiet) |=> $stable(cause_q));

endmodule

bind sata_port_csr spc_csr_chk #(.ADDR_W(ADDR_W), .DEVRST_CYC(DEVRST_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_addr     (bus_addr),
   .evt_i        (evt_i),
   .ctrl_o       (ctrl_o),
   .port_ready_o (port_ready_o),
   .irq_o        (irq_o),
   .en_q         (en_q),
   .cause_q      (cause_q)
);

// File: tb/tb_sata_port_csr.sv
module tb_sata_port_csr;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 12;
   localparam int NCYC   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] evt_i = '0;
   logic [13:0] ctrl_o;
   logic        port_ready_o;
   logic        irq_o;
   logic [1:0]  irq_steer_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [ADDR_W-1:0] addr;
      logic [31:0]       exp;
      string             tag;
   } rd_item_t;
   rd_item_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   sata_port_csr #(.ADDR_W(ADDR_W), .DEVRST_CYC(NCYC)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_i(evt_i), .ctrl_o(ctrl_o), .port_ready_o(port_ready_o),
      .irq_o(irq_o), .irq_steer_o(irq_steer_o));

   // monitor: pops expected read data and compares mid-cycle
   always @(negedge clk) begin
      if (bus_rd && sb.size() > 0) begin
         rd_item_t it;
         it = sb.pop_front();
         n_chk++;
         if (bus_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: read 0x%03h got 0x%08h exp 0x%08h",
                     it.tag, it.addr, bus_rdata, it.exp);
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h exp 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
      rd_item_t it;
      it.addr = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] e);
      evt_i = e;
      @(posedge clk); #1;
      evt_i = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, got hang exp completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk(32'(irq_o), 0, "R1 irq after reset");
      rd(12'h000, 32'h0000_0001, "R1 status after reset");
      rd(12'h010, 32'h0, "R1 enables after reset");
      rd(12'h008, 32'h0, "R1 causes after reset");

      // R3 port reset release makes port ready
      wr(12'h004, 32'h1);
      rd(12'h000, 32'h8000_0000, "R3 ready after port reset cleared");
      chk(32'(port_ready_o), 1, "R3 ready pin");

      // R2 set/clear, unimplemented bits ignored
      wr(12'h000, 32'hFFFF_FFFD);
      rd(12'h000, 32'h0000_244D, "R2 set all but device reset, R3 ready low");
      wr(12'h004, 32'h0000_2405);
      rd(12'h000, 32'h8000_0048, "R2 selective clear");
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h000, 32'h8000_0000, "R2 clear all");

      // R5 enables and steering
      wr(12'h010, 32'hC000_0FFF);
      rd(12'h010, 32'hC000_087F, "R5 enable set");
      chk(32'(irq_steer_o), 3, "R5 steer set");
      wr(12'h014, 32'h4000_0002);
      rd(12'h010, 32'h8000_087D, "R5 enable clear");
      chk(32'(irq_steer_o), 2, "R5 steer clear");

      // R6/R7 disabled cause raw only
      pulse(12'h002);
      chk(32'(irq_o), 0, "R7 disabled cause no irq");
      rd(12'h008, 32'h0002_0000, "R6 raw only");
      rd(12'h008, 32'h0002_0000, "R8 unmasked cause stays after read");
      pulse(12'h780);
      rd(12'h008, 32'h0002_0000, "R6 unimplemented events ignored");

      // R6/R7/R8 enabled causes, clear on read
      pulse(12'h801);
      chk(32'(irq_o), 1, "R7 irq one cycle after pulse");
      rd(12'h008, 32'h0803_0801, "R6 raw and masked halves");
      rd(12'h008, 32'h0002_0000, "R8 read cleared masked causes");
      chk(32'(irq_o), 0, "R8 irq drops after read");
      wr(12'h008, 32'h0FFF_0FFF);
      rd(12'h008, 32'h0002_0000, "R8 write ignored in read-clear mode");

      // R9 write-one-to-clear mode
      wr(12'h000, 32'h8);
      pulse(12'h010);
      rd(12'h008, 32'h0012_0010, "R9 first read");
      rd(12'h008, 32'h0012_0010, "R9 read does not clear");
      wr(12'h008, 32'h0000_0010);
      rd(12'h008, 32'h0002_0000, "R9 low-half clear");
      chk(32'(irq_o), 0, "R7 irq drops after write clear");
      wr(12'h008, 32'h0002_0000);
      rd(12'h008, 32'h0, "R9 high-half clear");
      pulse(12'h87F);
      wr(12'h008, 32'h0FFF_0FFF);
      rd(12'h008, 32'h0, "R9 full clear word");

      // R10 event beats simultaneous clear
      evt_i = 12'h004;
      wr(12'h008, 32'h0000_0004);
      evt_i = '0;
      rd(12'h008, 32'h0004_0004, "R10 event wins over clear");
      wr(12'h008, 32'h0000_0004);

      // R4 device reset sequence
      pulse(12'h001);
      wr(12'h000, 32'h2);
      chk(32'(port_ready_o), 0, "R4 not ready during device reset");
      repeat (NCYC-1) @(posedge clk);
      #1;
      chk(32'(ctrl_o[1]), 1, "R4 device reset still set at last cycle");
      @(posedge clk); #1;
      chk(32'(ctrl_o[1]), 0, "R4 device reset self-cleared");
      chk(32'(port_ready_o), 1, "R4 ready after device reset");
      chk(32'(irq_o), 0, "R4 irq after flush");
      rd(12'h008, 32'h0, "R4 causes flushed");
      rd(12'h000, 32'h8000_0008, "R4 status after device reset");

      @(posedge clk); #1;
      finish_run();
   end

endmodule